// File: doc/BRIEF.md
# Serial Register Slave with Timekeeping Freeze

This block is a two-wire serial bus target that serves a byte-wide register space. The lowest eight locations mirror a running time-of-day counter. The other locations are plain storage. The block samples SCL and SDA through synchronizers. It pulls SDA low through an open-drain enable, and it keeps a volatile word pointer. That pointer selects the location that a write stores to or a read returns.

A host writes the word pointer with the first data byte of a write-direction transfer. Further data bytes in the same transfer are stored at consecutive locations. For a random read, the host sets the pointer with a write-direction address phase, then issues a repeated START in read direction. For a current-address read, the host addresses the block in read direction straight away, and the read starts at the location the pointer already holds.

The timekeeping counter outside this block offers a parallel snapshot together with a load strobe. The block copies that snapshot into its clock locations only while its update-allowed output is high. That output goes low while a selected transfer has the pointer on a clock location. This keeps a multi-byte time read coherent.

The control state machine has these states:
- `ST_IDLE`: unselected.
- `ST_ADDR`: target address byte.
- `ST_ADDR_ACK`: acknowledge of the target address.
- `ST_WADDR`: word-pointer byte.
- `ST_WADDR_ACK`: acknowledge of the word-pointer byte.
- `ST_WDATA`: data byte being written.
- `ST_WDATA_ACK`: acknowledge of a written data byte.
- `ST_RDATA`: data byte being sent.
- `ST_RACK`: host acknowledge of a sent byte.
- `ST_WAIT`: released, waiting for STOP or START.

It takes these transitions:
- START from any state leads to `ST_ADDR`.
- STOP from any state leads to `ST_IDLE`.
- From `ST_ADDR`, an address match leads to `ST_ADDR_ACK`; a mismatch leads to `ST_IDLE`.
- From `ST_ADDR_ACK`, read direction leads to `ST_RDATA` and write direction leads to `ST_WADDR`.
- `ST_WADDR` leads to `ST_WADDR_ACK`, which leads to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` leads to `ST_RACK`.
- From `ST_RACK`, a host ACK leads back to `ST_RDATA`; a host NACK leads to `ST_WAIT`.

Top module: `i2c_regslave`

## Requirements
- R1: The block acknowledges only a target address byte whose upper seven bits equal the parameter `SLV_ADDR` (default 7'b1101000, written as byte D0h/D1h). On any other address it leaves SDA released, including through the following bytes, until the next START.
- R2: In a write-direction transfer, the first byte after the address acknowledge loads the word pointer.
- R3: Each later byte of a write-direction transfer is stored at the pointed location and acknowledged. The pointer then advances by one at the acknowledge clock.
- R4: A read returns the byte at the pointer, MSB first. The pointer advances only when the host acknowledges on the acknowledge clock, and the next byte comes from the advanced location.
- R5: When the host does not acknowledge a read byte, the block releases SDA, keeps the pointer, and waits for STOP or START.
- R6: A read-direction address with no pointer write (current-address read) starts at the location the pointer last held.
- R7: The pointer wraps from `MAX_ADDR` (default 3Fh) to 00h.
- R8: While the block is selected and the pointer is below `CLK_REGS` (default 8), `tk_upd_ok` is 0. Snapshot byte i (`tk_time[8i+7:8i]`) enters clock location i only on a cycle with `tk_load` and `tk_upd_ok` both high.
- R9: A STOP condition ends the freeze, so `tk_upd_ok` is 1 on the cycle after STOP is detected.
- R10: In both directions, the freeze ends inside a transfer when the pointer advances from 07h to 08h.
- R11: After reset, `sda_oe` is 0 and `tk_upd_ok` is 1. `sda_oe` changes only while the synchronized SCL is low.
- R12: A snapshot load and a bus write to a non-clock location in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| tk_time | input | 8*CLK_REGS | Parallel snapshot from the time counter, byte i for location i |
| tk_load | input | 1 | Strobe offering the snapshot for loading |
| tk_upd_ok | output | 1 | 1 when clock locations may take the snapshot |

## Verification
A bus write to a storage location and a snapshot load into the clock locations can fall in the same clock cycle. The bench provokes this by holding `tk_load` high throughout a write-direction transfer to location 20h, so the store strobe is sure to coincide with a load. It then reads back both location 20h and the clock locations, and judges the result by checking that each holds its own new value with neither update lost.

// File: rtl/i2crs_pkg.sv
package i2crs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } slv_state_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

endpackage

// File: rtl/i2crs_sync.sv
module i2crs_sync
    import i2crs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output logic     scl_lvl,
    output logic     sda_lvl,
    output bus_evt_t evt
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_q;
    logic [DEPTH-1:0] sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[DEPTH-2:0], scl_i};
            sda_q <= {sda_q[DEPTH-2:0], sda_i};
        end
    end

    // level after STAGES flops; one extra flop gives the previous level
    assign scl_lvl = scl_q[DEPTH-2];
    assign sda_lvl = sda_q[DEPTH-2];

    always_comb begin
        evt.scl_rise = scl_q[DEPTH-2] & ~scl_q[DEPTH-1];
        evt.scl_fall = ~scl_q[DEPTH-2] & scl_q[DEPTH-1];
        evt.start    = scl_q[DEPTH-2] & scl_q[DEPTH-1] & ~sda_q[DEPTH-2] & sda_q[DEPTH-1];
        evt.stop     = scl_q[DEPTH-2] & scl_q[DEPTH-1] & sda_q[DEPTH-2] & ~sda_q[DEPTH-1];
    end

endmodule

// File: rtl/i2crs_regs.sv
module i2crs_regs #(
    parameter int MAX_ADDR = 63,
    parameter int CLK_REGS = 8,
    localparam int NREG  = MAX_ADDR + 1,
    localparam int PTR_W = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [PTR_W-1:0]      rd_addr,
    output logic [7:0]            rd_data,
    input  logic [8*CLK_REGS-1:0] snap,
    input  logic                  snap_load,
    input  logic                  upd_ok
);
    logic [8*NREG-1:0] flat;
    logic              snap_take;

    assign snap_take = snap_load & upd_ok;

    for (genvar i = 0; i < NREG; i++) begin : g_loc
        logic [7:0] q;
        logic       hit;
        assign hit = wr_en && (wr_addr == PTR_W'(i));
        if (i < CLK_REGS) begin : g_clk
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         q <= '0;
                else if (hit)       q <= wr_data;
                else if (snap_take) q <= snap[8*i +: 8];
            end
        end else begin : g_ram
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q <= '0;
                else if (hit) q <= wr_data;
            end
        end
        assign flat[8*i +: 8] = q;
    end

    assign rd_data = flat[rd_addr*8 +: 8];

endmodule

// File: rtl/i2crs_fsm.sv
module i2crs_fsm
    import i2crs_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'b1101000,
    parameter int         MAX_ADDR = 63,
    localparam int        PTR_W    = $clog2(MAX_ADDR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_evt_t         evt,
    input  logic             sda_lvl,
    input  logic [7:0]       rd_data,
    output logic             sda_oe,
    output logic [PTR_W-1:0] ptr,
    output logic             sel,
    output logic             wr_en,
    output logic [7:0]       wr_data
);
    slv_state_t       st, nxt;
    logic [3:0]       cnt;
    logic [7:0]       shreg;
    logic [7:0]       txsh;
    logic             rw;
    logic             ackd;
    logic             got8;
    logic             addr_hit;
    logic [PTR_W-1:0] ptr_nx;
    logic [PTR_W-1:0] word_ptr;

    assign got8     = (cnt == 4'd8);
    assign addr_hit = (shreg[7:1] == SLV_ADDR);
    assign ptr_nx   = (ptr == PTR_W'(MAX_ADDR)) ? '0 : ptr + 1'b1;
    assign word_ptr = (shreg > 8'(MAX_ADDR)) ? '0 : shreg[PTR_W-1:0];

    // next state
    always_comb begin
        nxt = st;
        if (evt.stop) begin
            nxt = ST_IDLE;
        end else if (evt.start) begin
            nxt = ST_ADDR;
        end else begin
            unique case (st)
                ST_IDLE, ST_WAIT: nxt = st;
                ST_ADDR:      if (evt.scl_fall && got8) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (evt.scl_fall) nxt = rw ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (evt.scl_fall && got8) nxt = ST_WADDR_ACK;
                ST_WADDR_ACK: if (evt.scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (evt.scl_fall && got8) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (evt.scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (evt.scl_fall && cnt == 4'd7) nxt = ST_RACK;
                ST_RACK:      if (evt.scl_fall) nxt = ackd ? ST_RDATA : ST_WAIT;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // datapath: bit counter, shifters, pointer, selection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            txsh  <= '0;
            rw    <= 1'b0;
            ackd  <= 1'b0;
            sel   <= 1'b0;
            ptr   <= '0;
        end else if (evt.stop) begin
            sel <= 1'b0;
        end else if (evt.start) begin
            cnt <= '0;
        end else begin
            unique case (st)
                ST_ADDR, ST_WADDR, ST_WDATA: begin
                    if (evt.scl_rise && !got8) begin
                        shreg <= {shreg[6:0], sda_lvl};
                        cnt   <= cnt + 1'b1;
                    end
                    if (evt.scl_fall && got8) begin
                        if (st == ST_ADDR) begin
                            sel <= addr_hit;
                            rw  <= shreg[0];
                        end
                        if (st == ST_WADDR) ptr <= word_ptr;
                    end
                end
                ST_ADDR_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (evt.scl_fall) begin
                        cnt <= '0;
                        if (st == ST_ADDR_ACK && rw) txsh <= rd_data;
                        if (st == ST_WDATA_ACK)      ptr  <= ptr_nx;
                    end
                end
                ST_RDATA: begin
                    if (evt.scl_fall) begin
                        if (cnt == 4'd7) begin
                            cnt <= '0;
                        end else begin
                            txsh <= {txsh[6:0], 1'b0};
                            cnt  <= cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (evt.scl_rise) begin
                        ackd <= ~sda_lvl;
                        if (!sda_lvl) ptr <= ptr_nx;
                    end
                    if (evt.scl_fall && ackd) begin
                        txsh <= rd_data;
                        cnt  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            ST_ADDR_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                                sda_oe = ~txsh[7];
            default:                                 sda_oe = 1'b0;
        endcase
        wr_en   = (st == ST_WDATA) && evt.scl_fall && got8;
        wr_data = shreg;
    end

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2crs_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'b1101000,
    parameter int         MAX_ADDR = 63,
    parameter int         CLK_REGS = 8,
    parameter int         SYNC_STG = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic [8*CLK_REGS-1:0] tk_time,
    input  logic                  tk_load,
    output logic                  tk_upd_ok
);
    localparam int PTR_W = $clog2(MAX_ADDR + 1);

    logic             scl_lvl;
    logic             sda_lvl;
    bus_evt_t         evt;
    logic [PTR_W-1:0] ptr;
    logic             sel;
    logic             wr_en;
    logic [7:0]       wr_data;
    logic [7:0]       rd_data;

    i2crs_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_lvl (scl_lvl),
        .sda_lvl (sda_lvl),
        .evt     (evt)
    );

    i2crs_fsm #(.SLV_ADDR(SLV_ADDR), .MAX_ADDR(MAX_ADDR)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .sda_lvl (sda_lvl),
        .rd_data (rd_data),
        .sda_oe  (sda_oe),
        .ptr     (ptr),
        .sel     (sel),
        .wr_en   (wr_en),
        .wr_data (wr_data)
    );

    // freeze while a selected transfer points into the clock locations
    assign tk_upd_ok = ~(sel && (int'(ptr) < CLK_REGS));

    i2crs_regs #(.MAX_ADDR(MAX_ADDR), .CLK_REGS(CLK_REGS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (ptr),
        .wr_data   (wr_data),
        .rd_addr   (ptr),
        .rd_data   (rd_data),
        .snap      (tk_time),
        .snap_load (tk_load),
        .upd_ok    (tk_upd_ok)
    );

endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk
    import i2crs_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             tk_upd_ok,
    input logic             scl_lvl,
    input bus_evt_t         evt,
    input logic [PTR_W-1:0] ptr,
    input logic             sel,
    input logic             wr_en
);

    AST_OE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl); // R11

    AST_STOP_UNFREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> tk_upd_ok); // R9

    AST_PTR_ON_SCL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> $past(evt.scl_rise || evt.scl_fall)); // R3

    AST_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !sda_oe); // R1

    AST_WRITE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sel); // R3

endmodule

bind i2c_regslave i2c_regslave_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .tk_upd_ok (tk_upd_ok),
    .scl_lvl   (scl_lvl),
    .evt       (evt),
    .ptr       (ptr),
    .sel       (sel),
    .wr_en     (wr_en)
);

// File: tb/i2c_regslave_tb.sv
module i2c_regslave_tb;
    localparam int Q  = 10;
    localparam int NC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_oe;
    logic          sda_line;
    logic [8*NC-1:0] tk_time = '0;
    logic          tk_load = 1'b0;
    logic          tk_upd_ok;
    int            total = 0;
    int            bad = 0;
    logic [7:0]    got [16];
    logic [7:0]    wdat [16];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regslave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .tk_time   (tk_time),
        .tk_load   (tk_load),
        .tk_upd_ok (tk_upd_ok)
    );

    task automatic chk(input string rq, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic b_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic b_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic wbit(input logic b);
        sda_m = b;    qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        b = sda_line; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        wbit(~give_ack);
    endtask

    // write n bytes from wdat starting at word address wa
    task automatic do_write(input logic [7:0] wa, input int n, input string rq);
        logic a;
        b_start();
        send_byte(8'hD0, a); chk("R1", a, 1);
        send_byte(wa, a);    chk("R2", a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wdat[i], a);
            chk(rq, a, 1);
        end
        b_stop();
    endtask

    // read n bytes into got; random read when rnd, else current-address
    task automatic do_read(input bit rnd, input logic [7:0] wa, input int n);
        logic a;
        b_start();
        if (rnd) begin
            send_byte(8'hD0, a); chk("R1", a, 1);
            send_byte(wa, a);    chk("R2", a, 1);
            b_start();
        end
        send_byte(8'hD1, a); chk("R1", a, 1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, got[i]);
        b_stop();
    endtask

    task automatic t_reset();
        chk("R11 oe", sda_oe, 0);
        chk("R11 upd", tk_upd_ok, 1);
    endtask

    task automatic t_foreign_addr();
        logic a;
        b_start();
        send_byte(8'hA2, a); chk("R1 foreign", a, 0);
        send_byte(8'h00, a); chk("R1 stays quiet", a, 0);
        b_stop();
    endtask

    task automatic t_write_read();
        wdat[0] = 8'hA1; wdat[1] = 8'hB2; wdat[2] = 8'hC3;
        do_write(8'h10, 3, "R3");
        do_read(1'b1, 8'h10, 3);
        chk("R4 b0", got[0], 8'hA1);
        chk("R4 b1", got[1], 8'hB2);
        chk("R4 b2", got[2], 8'hC3);
    endtask

    task automatic t_current_read();
        // NACK on last byte above left the pointer at 12h
        do_read(1'b0, 8'h00, 1);
        chk("R5 R6 cur", got[0], 8'hC3);
    endtask

    task automatic t_wrap();
        wdat[0] = 8'h5A; wdat[1] = 8'h6B;
        do_write(8'h3F, 2, "R7");
        do_read(1'b1, 8'h3F, 2);
        chk("R7 top", got[0], 8'h5A);
        chk("R7 wrap", got[1], 8'h6B);
    endtask

    task automatic t_freeze_stop();
        logic a;
        for (int i = 0; i < NC; i++) tk_time[8*i +: 8] = 8'(8'h80 + i);
        b_start();
        send_byte(8'hD0, a);
        send_byte(8'h03, a);
        chk("R8 frozen", tk_upd_ok, 0);
        tk_load = 1'b1; @(negedge clk); tk_load = 1'b0;
        b_stop();
        chk("R9 stop", tk_upd_ok, 1);
        do_read(1'b1, 8'h00, NC);
        chk("R8 held0", got[0], 8'h6B);
        chk("R8 held5", got[5], 8'h00);
        tk_load = 1'b1; @(negedge clk); tk_load = 1'b0;
        do_read(1'b1, 8'h00, NC);
        for (int i = 0; i < NC; i++) chk("R8 load", got[i], 8'h80 + i);
    endtask

    task automatic t_lift_write();
        logic a;
        b_start();
        send_byte(8'hD0, a);
        send_byte(8'h06, a);
        send_byte(8'h11, a); chk("R3", a, 1);
        chk("R10 w still", tk_upd_ok, 0);
        send_byte(8'h22, a);
        chk("R10 w lift", tk_upd_ok, 1);
        b_stop();
    endtask

    task automatic t_lift_read();
        logic a;
        logic [7:0] v;
        b_start();
        send_byte(8'hD0, a);
        send_byte(8'h07, a);
        b_start();
        send_byte(8'hD1, a);
        chk("R10 r still", tk_upd_ok, 0);
        recv_byte(1'b1, v);
        chk("R4 r07", v, 8'h22);
        chk("R10 r lift", tk_upd_ok, 1);
        recv_byte(1'b0, v);
        chk("R4 r08", v, 8'h00);
        b_stop();
    endtask

    task automatic t_same_cycle();
        for (int i = 0; i < NC; i++) tk_time[8*i +: 8] = 8'(8'h40 + i);
        wdat[0] = 8'h77;
        tk_load = 1'b1;
        do_write(8'h20, 1, "R12");
        tk_load = 1'b0;
        do_read(1'b1, 8'h20, 1);
        chk("R12 ram", got[0], 8'h77);
        do_read(1'b1, 8'h00, NC);
        chk("R12 clk0", got[0], 8'h40);
        chk("R12 clk7", got[7], 8'h47);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_foreign_addr();
        t_write_read();
        t_current_read();
        t_wrap();
        t_freeze_stop();
        t_lift_write();
        t_lift_read();
        t_same_cycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule